// File: doc/BRIEF.md
# Down-Counting Timer with Compare and Two-Phase Output

This block is a down-counter with a programmable reload value, a threshold comparator and a small set of run conditions. Software loads a control word, a second control word, the reload value and the threshold through a plain write port. The counter then steps down once per cycle while its run condition holds. When a step finds the count at zero, the counter reloads and a one-cycle terminal pulse is raised. A comparator continuously tests the running count against the active threshold. Its result drives the compare output, or, in split mode, two non-overlapping phase outputs separated by a programmable gap.

The run condition comes from the configuration and from an external enable pin, which is synchronized and can be inverted. Four conditions are available: always running, running inside a high window of the pin, running between successive rising edges of the pin, and running until the interrupt fires. A one-shot option freezes the counter after its first terminal event. A sticky two-bit status register records terminal and compare events. It is cleared by a read strobe unless it is set to keep its contents. The interrupt follows either the raw events or the sticky status. The block moves no data stream. Every pin is a plain control or status signal, so there is no back-pressure anywhere.

Top module: `ctc_timer`

Register map (write port, `cfg_addr_i`):
- 0, control word: bit0 run enable, bit1 show threshold on `cnt_o`, bit2 one-shot, bit3 buffered threshold, bit4 invert pin, bit5 split (two-phase) output, bits7:6 gap select, bits9:8 run condition, bit10 blank outputs while disabled, bit11 clear output state while disabled, bits14:12 relation, bit15 pin gating in free mode.
- 1, auxiliary word: bit0 interrupt from status, bit1 start pulse, bit2 keep status on read.
- 2, reload value.
- 3, threshold.

## Requirements
- R1: After reset, `cmp_o`, `tc_o`, `irq_o`, `cnt_o` and `status_o` are all zero.
- R2: While disabled, the count loads the reload value each cycle. While enabled and stepping, it decrements by one. A step at zero reloads the count and raises `tc_o` for exactly the next cycle.
- R3: In run condition 0, the counter steps every cycle, unless bit15 is set. With bit15 set, it steps only while the synchronized pin is high. The pin is taken through two flops, and bit4 inverts its sense.
- R4: Run condition 1 opens a window on a rising edge of the synchronized pin and closes it on a falling edge. The counter steps only inside the window.
- R5: Run condition 2 toggles the window on every rising edge of the synchronized pin, so counting spans from one rising edge to the next.
- R6: Run condition 3 steps until `irq_o` is high, then halts until the block is disabled.
- R7: With one-shot set, the first terminal step halts the counter. Only disabling and then re-enabling restarts it.
- R8: The relation field compares the count c with the threshold t: 0 gives c==t, 1 gives c<t, 2 gives c<=t, 3 gives c>t, 4 gives c>=t, and 5 to 7 give never. The registered result appears on `cmp_o` one cycle later. With bit1 set, `cnt_o` shows the active threshold instead of the count.
- R9: With bit3 clear, a threshold write takes effect at once. With bit3 set, the write goes to a shadow register, which becomes active on the next terminal step.
- R10: With the start-pulse bit set, `tc_o` pulses for one cycle in the cycle after the enable bit goes from 0 to 1.
- R11: In split mode, `cmp_o` carries the high phase and `tc_o` the low phase of the compare result. After each change of that result, both outputs are low for gap+1 cycles (1 to 4). The two outputs are never high together.
- R12: Bit10 holds `cmp_o` and `tc_o` at zero while disabled. Bit11 clears the compare and phase state while disabled.
- R13: Status bit0 records terminal pulses and bit1 records rising edges of the compare result. These bits hold until a `stat_rd_i` strobe clears them; the strobe has no effect when the keep bit is set. `irq_o` is the OR of the raw events, or the OR of the status bits when the auxiliary bit0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | W | Configuration write data |
| stat_rd_i | input | 1 | Status read strobe (clears unless keep) |
| tmr_en_i | input | 1 | External asynchronous run-enable pin |
| cmp_o | output | 1 | Compare output or high phase |
| tc_o | output | 1 | Terminal pulse or low phase |
| irq_o | output | 1 | Interrupt |
| cnt_o | output | W | Count, or active threshold |
| status_o | output | 2 | Sticky status {compare, terminal} |

## Verification
A configuration write becomes visible one cycle after its strobe edge. A pin change affects the synchronized level two edges later, the window a third edge later and the count a fourth edge later. The terminal pulse, the compare result and the interrupt follow the step that produced them by one cycle. Phase outputs trail the compare result by another cycle plus the gap. The bench model advances on the same rising edge as the design and counts those register stages itself. Outputs are compared against it at every falling edge, so each result is sampled in the cycle it is due and a result that comes one cycle early or late shows up as a miscompare.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CFG_W = 16;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_AUX  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam logic [1:0] A_THR  = 2'd3;

  localparam logic [1:0] RUN_FREE  = 2'd0;
  localparam logic [1:0] RUN_WIDTH = 2'd1;
  localparam logic [1:0] RUN_SPAN  = 2'd2;
  localparam logic [1:0] RUN_IRQ   = 2'd3;

  typedef struct packed {
    logic       pin_gate;
    logic [2:0] rel;
    logic       clr_dis;
    logic       blank_dis;
    logic [1:0] run;
    logic [1:0] gap_sel;
    logic       split;
    logic       inv;
    logic       buf_thr;
    logic       oneshot;
    logic       view_thr;
    logic       en;
  } ctl_t;

  typedef struct packed {
    logic keep;
    logic start_pulse;
    logic irq_stat;
  } aux_t;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign lvl_o = sh_q[STAGES-1] ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  input  logic         thr_we_i,
  input  logic [W-1:0] thr_wdata_i,
  input  logic         buf_thr_i,
  input  logic [2:0]   rel_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] thr_o,
  output logic         zero_step_o,
  output logic         rel_hit_o
);
  logic [W-1:0] count_q, shadow_q, thr_q;

  assign zero_step_o = step_i && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      count_q <= '0;
    else if (!en_i)   count_q <= period_i;
    else if (step_i)  count_q <= (count_q == '0) ? period_i : count_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      shadow_q <= '0;
      thr_q    <= '0;
    end else begin
      if (thr_we_i) shadow_q <= thr_wdata_i;
      if (thr_we_i && !buf_thr_i)         thr_q <= thr_wdata_i;
      else if (buf_thr_i && zero_step_o)  thr_q <= shadow_q;
    end

  always_comb begin
    unique case (rel_i)
      3'd0:    rel_hit_o = (count_q == thr_q);
      3'd1:    rel_hit_o = (count_q <  thr_q);
      3'd2:    rel_hit_o = (count_q <= thr_q);
      3'd3:    rel_hit_o = (count_q >  thr_q);
      3'd4:    rel_hit_o = (count_q >= thr_q);
      default: rel_hit_o = 1'b0;
    endcase
  end

  assign count_o = count_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage #(
  parameter int unsigned GSW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           rel_hit_i,
  input  logic           tc_evt_i,
  input  logic           split_i,
  input  logic [GSW-1:0] gap_sel_i,
  input  logic           blank_dis_i,
  input  logic           clr_dis_i,
  output logic           cmp_r_o,
  output logic           tc_r_o,
  output logic           cmp_o,
  output logic           tc_o
);
  localparam int unsigned GW = GSW + 1;

  logic          cmp_q, tc_q, lvl_q;
  logic [GW-1:0] gap_q;
  logic          live, blank;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmp_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= tc_evt_i;
      if (en_i)           cmp_q <= rel_hit_i;
      else if (clr_dis_i) cmp_q <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else if (!en_i && clr_dis_i) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else begin
      lvl_q <= cmp_q;
      if (cmp_q != lvl_q)  gap_q <= {1'b0, gap_sel_i} + 1'b1;
      else if (gap_q != 0) gap_q <= gap_q - 1'b1;
    end

  assign live  = (gap_q == '0);
  assign blank = blank_dis_i && !en_i;

  assign cmp_o   = blank ? 1'b0 : (split_i ? (lvl_q && live)  : cmp_q);
  assign tc_o    = blank ? 1'b0 : (split_i ? (!lvl_q && live) : tc_q);
  assign cmp_r_o = cmp_q;
  assign tc_r_o  = tc_q;
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [1:0]   cfg_addr_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic         stat_rd_i,
  input  logic         tmr_en_i,
  output logic         cmp_o,
  output logic         tc_o,
  output logic         irq_o,
  output logic [W-1:0] cnt_o,
  output logic [1:0]   status_o
);
  ctl_t         ctl_q;
  aux_t         aux_q;
  logic [W-1:0] per_q;
  logic         en_q, win_q, halt_q, cmp_prev_q;
  logic [1:0]   stat_q;

  logic         pin_lvl, pin_rise, pin_fall;
  logic         gate, step, zero_step, rel_hit, tc_evt;
  logic         cmp_r, tc_r;
  logic [1:0]   ev;
  logic [W-1:0] count, thr;
  logic         run_en, split_en, blank_en;

  assign run_en   = ctl_q.en;
  assign split_en = ctl_q.split;
  assign blank_en = ctl_q.blank_dis;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctl_q <= '0;
      aux_q <= '0;
      per_q <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        A_CTL:   ctl_q <= ctl_t'(cfg_wdata_i[CFG_W-1:0]);
        A_AUX:   aux_q <= aux_t'(cfg_wdata_i[2:0]);
        A_PER:   per_q <= cfg_wdata_i;
        default: ;
      endcase
    end

  tmr_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (tmr_en_i), .inv_i (ctl_q.inv),
    .lvl_o (pin_lvl), .rise_o (pin_rise), .fall_o (pin_fall)
  );

  always_comb begin
    unique case (ctl_q.run)
      RUN_FREE:  gate = !ctl_q.pin_gate || pin_lvl;
      RUN_WIDTH: gate = win_q;
      RUN_SPAN:  gate = win_q;
      default:   gate = 1'b1;
    endcase
  end

  assign step = ctl_q.en && !halt_q && gate;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          win_q <= 1'b0;
    else if (!ctl_q.en)   win_q <= 1'b0;
    else if (ctl_q.run == RUN_WIDTH) begin
      if (pin_rise)       win_q <= 1'b1;
      else if (pin_fall)  win_q <= 1'b0;
    end else if (ctl_q.run == RUN_SPAN && pin_rise)
      win_q <= !win_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        halt_q <= 1'b0;
    else if (!ctl_q.en) halt_q <= 1'b0;
    else if ((ctl_q.oneshot && zero_step) || (ctl_q.run == RUN_IRQ && irq_o))
      halt_q <= 1'b1;

  tmr_count_core #(.W(W)) u_core (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (ctl_q.en), .step_i (step),
    .period_i (per_q),
    .thr_we_i (cfg_we_i && cfg_addr_i == A_THR), .thr_wdata_i (cfg_wdata_i),
    .buf_thr_i (ctl_q.buf_thr), .rel_i (ctl_q.rel),
    .count_o (count), .thr_o (thr), .zero_step_o (zero_step), .rel_hit_o (rel_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ctl_q.en;

  assign tc_evt = ctl_q.en && (zero_step || (aux_q.start_pulse && !en_q));

  tmr_out_stage #(.GSW(2)) u_out (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (ctl_q.en), .rel_hit_i (rel_hit),
    .tc_evt_i (tc_evt), .split_i (ctl_q.split), .gap_sel_i (ctl_q.gap_sel),
    .blank_dis_i (ctl_q.blank_dis), .clr_dis_i (ctl_q.clr_dis),
    .cmp_r_o (cmp_r), .tc_r_o (tc_r), .cmp_o (cmp_o), .tc_o (tc_o)
  );

  assign ev = {cmp_r && !cmp_prev_q, tc_r};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmp_prev_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      cmp_prev_q <= cmp_r;
      stat_q     <= ((stat_rd_i && !aux_q.keep) ? 2'b00 : stat_q) | ev;
    end

  assign irq_o    = aux_q.irq_stat ? (|stat_q) : (|ev);
  assign status_o = stat_q;
  assign cnt_o    = ctl_q.view_thr ? thr : count;
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_en,
  input logic         split_en,
  input logic         blank_en,
  input logic         step,
  input logic         halt_q,
  input logic [W-1:0] count,
  input logic [W-1:0] per_q,
  input logic         stat_rd_i,
  input logic [1:0]   status_o,
  input logic         cmp_o,
  input logic         tc_o
);
  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && count != '0 |=> count == $past(count) - 1'b1);

  // R2
  load_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en |=> count == $past(per_q));

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en && halt_q |=> count == $past(count));

  // R13
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> (status_o & $past(status_o)) == $past(status_o));

  // R11
  split_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_en |-> !(cmp_o && tc_o));

  // R12
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_en && !run_en |-> !cmp_o && !tc_o);
endmodule

bind ctc_timer ctc_timer_chk #(.W(W)) u_ctc_timer_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .run_en (run_en), .split_en (split_en),
  .blank_en (blank_en), .step (step), .halt_q (halt_q), .count (count),
  .per_q (per_q), .stat_rd_i (stat_rd_i), .status_o (status_o),
  .cmp_o (cmp_o), .tc_o (tc_o)
);

// File: tb/test_ctc_timer.sv
module test_ctc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic        rd = 1'b0;
  logic        pin = 1'b0;
  logic        cmp_o, tc_o, irq_o;
  logic [15:0] cnt_o;
  logic [1:0]  status_o;

  int    vecs = 0;
  int    fails = 0;
  int    cyc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ctc_timer i_ctc_timer (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (we), .cfg_addr_i (addr),
    .cfg_wdata_i (wdata), .stat_rd_i (rd), .tmr_en_i (pin),
    .cmp_o (cmp_o), .tc_o (tc_o), .irq_o (irq_o), .cnt_o (cnt_o), .status_o (status_o)
  );

  // behavioural reference state
  logic [15:0] m_ctl = 0, m_per = 0, m_cnt = 0, m_sh = 0, m_thr = 0;
  logic [2:0]  m_aux = 0, m_gap = 0;
  logic        m_s1 = 0, m_s2 = 0, m_prev = 0, m_enq = 0, m_win = 0, m_halt = 0;
  logic        m_cmpr = 0, m_tcr = 0, m_lvl = 0, m_cmpp = 0;
  logic [1:0]  m_stat = 0;

  function automatic logic relate(int c, int t, int sel);
    case (sel)
      0: return c == t;
      1: return c < t;
      2: return c <= t;
      3: return c > t;
      4: return c >= t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_pin_lvl();
    return m_s2 ^ m_ctl[4];
  endfunction

  function automatic logic m_step();
    logic g;
    case (m_ctl[9:8])
      2'd0: g = !m_ctl[15] || m_pin_lvl();
      2'd1, 2'd2: g = m_win;
      default: g = 1'b1;
    endcase
    return m_ctl[0] && !m_halt && g;
  endfunction

  function automatic logic m_irq();
    if (m_aux[0]) return m_stat != 2'b00;
    return m_tcr || (m_cmpr && !m_cmpp);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_per = 0; m_cnt = 0; m_sh = 0; m_thr = 0; m_aux = 0; m_gap = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_enq = 0; m_win = 0; m_halt = 0;
      m_cmpr = 0; m_tcr = 0; m_lvl = 0; m_cmpp = 0; m_stat = 0;
    end else begin
      automatic logic en    = m_ctl[0];
      automatic logic lvl   = m_pin_lvl();
      automatic logic rise  = lvl && !m_prev;
      automatic logic fall  = !lvl && m_prev;
      automatic logic st    = m_step();
      automatic logic zero  = st && (m_cnt == 0);
      automatic logic hit   = relate(int'(m_cnt), int'(m_thr), int'(m_ctl[14:12]));
      automatic logic irq   = m_irq();
      automatic logic [1:0] ev = {m_cmpr && !m_cmpp, m_tcr};
      automatic logic tcev  = en && (zero || (m_aux[1] && !m_enq));
      automatic logic n_win = m_win, n_halt = m_halt, n_cmpr = m_cmpr, n_lvl = m_lvl;
      automatic logic [2:0]  n_gap = m_gap;
      automatic logic [15:0] n_cnt = m_cnt, n_thr = m_thr;

      if (!en) n_win = 0;
      else if (m_ctl[9:8] == 2'd1) begin
        if (rise) n_win = 1; else if (fall) n_win = 0;
      end else if (m_ctl[9:8] == 2'd2 && rise) n_win = !m_win;

      if (!en) n_halt = 0;
      else if ((m_ctl[2] && zero) || (m_ctl[9:8] == 2'd3 && irq)) n_halt = 1;

      if (!en) n_cnt = m_per;
      else if (st) n_cnt = (m_cnt == 0) ? m_per : m_cnt - 16'd1;

      if (we && addr == 2'd3 && !m_ctl[3]) n_thr = wdata;
      else if (m_ctl[3] && zero) n_thr = m_sh;

      if (en) n_cmpr = hit; else if (m_ctl[11]) n_cmpr = 0;

      if (!en && m_ctl[11]) begin n_lvl = 0; n_gap = 0; end
      else begin
        n_lvl = m_cmpr;
        if (m_cmpr != m_lvl) n_gap = 3'(m_ctl[7:6]) + 3'd1;
        else if (m_gap != 0) n_gap = m_gap - 3'd1;
      end

      m_stat = ((rd && !m_aux[2]) ? 2'b00 : m_stat) | ev;
      m_cmpp = m_cmpr;
      m_tcr  = tcev;
      m_cmpr = n_cmpr; m_lvl = n_lvl; m_gap = n_gap;
      m_cnt  = n_cnt;  m_thr = n_thr; m_win = n_win; m_halt = n_halt;
      m_enq  = en;
      m_prev = lvl;
      m_s2   = m_s1;
      m_s1   = pin;
      if (we) begin
        case (addr)
          2'd0: m_ctl = wdata;
          2'd1: m_aux = wdata[2:0];
          2'd2: m_per = wdata;
          default: m_sh = wdata;
        endcase
      end
    end
  end

  task automatic check(string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  // compare all outputs against the model on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic logic blank = m_ctl[10] && !m_ctl[0];
      automatic logic live  = (m_gap == 0);
      automatic logic e_cmp = blank ? 1'b0 : (m_ctl[5] ? (m_lvl && live)  : m_cmpr);
      automatic logic e_tc  = blank ? 1'b0 : (m_ctl[5] ? (!m_lvl && live) : m_tcr);
      check("cmp_o",    int'(cmp_o),    int'(e_cmp));
      check("tc_o",     int'(tc_o),     int'(e_tc));
      check("irq_o",    int'(irq_o),    int'(m_irq()));
      check("cnt_o",    int'(cnt_o),    int'(m_ctl[1] ? m_thr : m_cnt));
      check("status_o", int'(status_o), int'(m_stat));
    end
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL %s watchdog: actual 1 expected 0", cur_req);
    finish_up();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  localparam logic [15:0] EN = 16'h0001, VIEW = 16'h0002, OS = 16'h0004, BUFT = 16'h0008;
  localparam logic [15:0] INV = 16'h0010, SPLIT = 16'h0020, BLANK = 16'h0400;
  localparam logic [15:0] CLR = 16'h0800, HWG = 16'h8000;

  function automatic logic [15:0] rel(int r);
    return 16'(r) << 12;
  endfunction

  function automatic logic [15:0] run(int r);
    return 16'(r) << 8;
  endfunction

  function automatic logic [15:0] gap(int g);
    return 16'(g) << 6;
  endfunction

  initial begin
    idle(4);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R2";
    wr(2, 16'd5); wr(3, 16'd2); wr(0, EN); idle(20);

    cur_req = "R8";
    for (int r = 0; r < 6; r++) begin
      wr(0, EN | rel(r)); idle(8);
    end
    wr(0, EN | VIEW | rel(2)); idle(4);

    cur_req = "R3";
    wr(0, EN | HWG); pin = 1'b0; idle(6); pin = 1'b1; idle(6); pin = 1'b0; idle(5);
    wr(0, EN | HWG | INV); idle(6); pin = 1'b1; idle(5); pin = 1'b0;

    cur_req = "R4";
    wr(0, 16'h0); wr(0, EN | run(1));
    for (int k = 0; k < 2; k++) begin
      pin = 1'b1; idle(5); pin = 1'b0; idle(6);
    end

    cur_req = "R5";
    wr(0, 16'h0); wr(0, EN | run(2));
    for (int k = 0; k < 3; k++) begin
      pin = 1'b1; idle(3); pin = 1'b0; idle(4);
    end

    cur_req = "R6";
    wr(0, 16'h0); wr(0, EN | run(3)); idle(15);
    wr(0, 16'h0); wr(0, EN | run(3)); idle(10);

    cur_req = "R7";
    wr(0, 16'h0); wr(0, EN | OS); idle(15);
    wr(0, 16'h0); wr(0, EN | OS); idle(10);

    cur_req = "R9";
    wr(0, EN | rel(0)); wr(3, 16'd4); idle(6);
    wr(0, EN | BUFT | rel(0)); wr(3, 16'd1); idle(4); wr(3, 16'd3); idle(12);
    wr(0, EN | BUFT | VIEW); idle(8);

    cur_req = "R10";
    wr(1, 16'h2); wr(0, 16'h0); wr(0, EN); idle(4);
    wr(0, 16'h0); idle(2); wr(0, EN); idle(4); wr(1, 16'h0);

    cur_req = "R11";
    wr(3, 16'd2);
    wr(0, EN | SPLIT | gap(1) | rel(2)); idle(20);
    wr(0, EN | SPLIT | gap(3) | rel(2)); idle(20);
    wr(0, EN | SPLIT | gap(0) | rel(4)); idle(12);

    cur_req = "R12";
    wr(0, SPLIT | BLANK); idle(4);
    wr(0, EN | rel(1)); idle(6);
    wr(0, 16'h0); idle(3);
    wr(0, EN | rel(1)); idle(6);
    wr(0, CLR); idle(4);
    wr(0, EN | SPLIT | CLR | rel(1)); idle(8); wr(0, SPLIT | CLR); idle(4);

    cur_req = "R13";
    wr(1, 16'h0); wr(0, EN | rel(0)); idle(10);
    rd_pulse(); idle(4);
    wr(1, 16'h5); idle(3); rd_pulse(); idle(6);
    wr(1, 16'h1); rd_pulse(); idle(8);
    rd_pulse(); idle(4);

    finish_up();
  end
endmodule